// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block drives the secondary trigger output of a general-purpose timer. A 4-bit mode input picks one of sixteen sources. The first group of modes forwards a timer signal unchanged: the software update strobe, the counter-enable level, the update-event strobe, the channel-1 match strobe, or one of six compare reference levels.

The last six modes turn chosen edges of the compare references into single-cycle pulses. Those modes can also combine two channels, for example a rising edge on channel 4 or a falling edge on channel 6.

The output is registered, so every mode adds one clock of latency. Edge detection compares each reference with a copy held from the previous clock. Software controls the counter, the compare logic and the mode value outside this block. The block only selects and shapes the trigger.

Top module: `trig_out_sel`

## Requirements
- R1: While rst_n is low at a clock edge, trig_out becomes 0 and every stored reference history bit becomes 0. The first cycle after reset therefore treats each reference as having been low.
- R2: With mode_sel 0, trig_out follows sw_update. With mode_sel 2, trig_out follows update_evt.
- R3: With mode_sel 1, trig_out follows the counter-enable level. That level is cnt_en_sw AND (trig_gate_in OR NOT gated_mode).
- R4: With mode_sel 3, every cycle with ch1_match high gives one high output cycle. Back-to-back strobes give back-to-back high cycles, because no flag is kept.
- R5: With mode_sel 4 to 9, trig_out follows cmp_ref[0] to cmp_ref[5] in that order. Bit k of cmp_ref is channel k+1.
- R6: mode_sel 10 pulses on either edge of cmp_ref[3] (channel 4). mode_sel 11 pulses on either edge of cmp_ref[5] (channel 6).
- R7: mode_sel 12 pulses on a rising edge of channel 4 or channel 6. mode_sel 14 pulses on a rising edge of channel 5 or channel 6.
- R8: mode_sel 13 pulses on a rising edge of channel 4 or a falling edge of channel 6. mode_sel 15 pulses on a rising edge of channel 5 or a falling edge of channel 6.
- R9: Two qualifying edges in the same cycle give a single one-cycle pulse.
- R10: In every mode, trig_out reflects the inputs sampled at the previous rising clock edge, no sooner and no later.
- R11: The reference history updates in every mode. On entering a pulse mode, a reference that is steady since the last cycle gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 4 | Trigger source selection |
| sw_update | input | 1 | Software update-generation strobe |
| cnt_en_sw | input | 1 | Software counter-enable bit |
| trig_gate_in | input | 1 | Trigger input used for gating |
| gated_mode | input | 1 | High when the counter enable is gated by trig_gate_in |
| update_evt | input | 1 | Update-event strobe |
| ch1_match | input | 1 | Channel-1 capture/compare match strobe |
| cmp_ref | input | 6 | Compare reference levels; bit 0 is channel 1 |
| trig_out | output | 1 | Registered trigger output |

## Verification
Two features can land in the same cycle: two edges that each qualify in a dual-channel pulse mode, and a mode change that meets reference history recorded under the previous mode. Directed cases cover both. One makes channel 4 rise and channel 6 fall on the same clock in mode 13. The other toggles channel 4 while a level mode is active and then switches to mode 10 with the reference held still. A single high cycle followed by low is the expected result of the first case, and a low output is the expected result of the second. Random cycles with random modes and references repeat both situations, and each cycle is compared against a bench model that keeps its own copy of the previous references.

// File: rtl/trig_sel_pkg.sv
// Shared mode encoding and sizes for the trigger output selector.
package trig_sel_pkg;
    localparam int MODE_W = 4;
    localparam int CH_N   = 6;

    // Mode codes; numeric values are the external encoding of mode_sel.
    typedef enum logic [MODE_W-1:0] {
        TM_SWUPD   = 4'd0,
        TM_CNTEN   = 4'd1,
        TM_UPDEVT  = 4'd2,
        TM_MATCH1  = 4'd3,
        TM_REF1    = 4'd4,
        TM_REF2    = 4'd5,
        TM_REF3    = 4'd6,
        TM_REF4    = 4'd7,
        TM_REF5    = 4'd8,
        TM_REF6    = 4'd9,
        TM_BOTH4   = 4'd10,
        TM_BOTH6   = 4'd11,
        TM_R4_R6   = 4'd12,
        TM_R4_F6   = 4'd13,
        TM_R5_R6   = 4'd14,
        TM_R5_F6   = 4'd15
    } trig_mode_e;

    // Channel indices (zero-based) used by the pulse modes.
    localparam int IDX_CH4 = 3;
    localparam int IDX_CH5 = 4;
    localparam int IDX_CH6 = 5;
endpackage

// File: rtl/trig_ref_history.sv
// Edge finder for the compare references.
// Keeps a registered copy of each reference and reports rising and falling
// edges against it. The copy updates every cycle regardless of mode.
// Assumes cmp_ref is synchronous to clk.
module trig_ref_history #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ref_now,
    output logic [NCH-1:0] ref_rise,
    output logic [NCH-1:0] ref_fall
);
    logic [NCH-1:0] ref_prev;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Hold last cycle's level; cleared low by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) ref_prev[g] <= 1'b0;
            else        ref_prev[g] <= ref_now[g];
        end
        // Compare current level with the stored one.
        assign ref_rise[g] =  ref_now[g] & ~ref_prev[g];
        assign ref_fall[g] = ~ref_now[g] &  ref_prev[g];
    end
endmodule

// File: rtl/trig_level_mux.sv
// Level source selector for modes 0 to 9.
// Returns 0 for any pulse mode; the top picks the pulse path there.
// Assumes at least six compare channels.
module trig_level_mux
    import trig_sel_pkg::*;
#(
    parameter int NCH = 6
) (
    input  trig_mode_e     mode,
    input  logic           sw_update,
    input  logic           cnt_en,
    input  logic           update_evt,
    input  logic           ch1_match,
    input  logic [NCH-1:0] cmp_ref,
    output logic           level
);
    localparam int IDX_W = $clog2(NCH);

    logic [IDX_W-1:0] ref_idx;

    // Map a reference mode to its zero-based channel index.
    always_comb ref_idx = IDX_W'(mode - TM_REF1);

    // Pick the level that matches the mode.
    always_comb begin
        unique case (mode)
            TM_SWUPD:  level = sw_update;
            TM_CNTEN:  level = cnt_en;
            TM_UPDEVT: level = update_evt;
            TM_MATCH1: level = ch1_match;
            TM_REF1, TM_REF2, TM_REF3,
            TM_REF4, TM_REF5, TM_REF6:
                       level = cmp_ref[ref_idx];
            default:   level = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_pulse_gen.sv
// Edge-pulse combiner for modes 10 to 15.
// Merges the selected edges by OR, so edges that coincide give one pulse.
// Returns 0 for level modes.
module trig_pulse_gen
    import trig_sel_pkg::*;
#(
    parameter int NCH = 6
) (
    input  trig_mode_e     mode,
    input  logic [NCH-1:0] ref_rise,
    input  logic [NCH-1:0] ref_fall,
    output logic           pulse
);
    logic both4, both6;

    // Either-edge terms for the single-channel modes.
    always_comb begin
        both4 = ref_rise[IDX_CH4] | ref_fall[IDX_CH4];
        both6 = ref_rise[IDX_CH6] | ref_fall[IDX_CH6];
    end

    // Edge combination per pulse mode.
    always_comb begin
        unique case (mode)
            TM_BOTH4: pulse = both4;
            TM_BOTH6: pulse = both6;
            TM_R4_R6: pulse = ref_rise[IDX_CH4] | ref_rise[IDX_CH6];
            TM_R4_F6: pulse = ref_rise[IDX_CH4] | ref_fall[IDX_CH6];
            TM_R5_R6: pulse = ref_rise[IDX_CH5] | ref_rise[IDX_CH6];
            TM_R5_F6: pulse = ref_rise[IDX_CH5] | ref_fall[IDX_CH6];
            default:  pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_out_sel.sv
// Secondary trigger output selector of a timer.
// Forms the counter-enable level, selects a level or edge-pulse source by
// mode_sel and registers the result, so the output lags its inputs by one
// clock. Assumes all inputs are synchronous to clk.
module trig_out_sel
    import trig_sel_pkg::*;
#(
    parameter int NCH = CH_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              sw_update,
    input  logic              cnt_en_sw,
    input  logic              trig_gate_in,
    input  logic              gated_mode,
    input  logic              update_evt,
    input  logic              ch1_match,
    input  logic [NCH-1:0]    cmp_ref,
    output logic              trig_out
);
    trig_mode_e     mode;
    logic           cnt_en;
    logic [NCH-1:0] ref_rise, ref_fall;
    logic           level, pulse, next_out, trig_q;

    // Decode the raw mode field.
    always_comb mode = trig_mode_e'(mode_sel);

    // Counter enable: software bit, gated by the trigger input when asked.
    always_comb cnt_en = cnt_en_sw & (trig_gate_in | ~gated_mode);

    trig_ref_history #(.NCH(NCH)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_now  (cmp_ref),
        .ref_rise (ref_rise),
        .ref_fall (ref_fall)
    );

    trig_level_mux #(.NCH(NCH)) u_lvl (
        .mode       (mode),
        .sw_update  (sw_update),
        .cnt_en     (cnt_en),
        .update_evt (update_evt),
        .ch1_match  (ch1_match),
        .cmp_ref    (cmp_ref),
        .level      (level)
    );

    trig_pulse_gen #(.NCH(NCH)) u_pls (
        .mode     (mode),
        .ref_rise (ref_rise),
        .ref_fall (ref_fall),
        .pulse    (pulse)
    );

    // Choose the pulse path for modes 10 and above.
    always_comb next_out = (mode >= TM_BOTH4) ? pulse : level;

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= next_out;
    end

    assign trig_out = trig_q;
endmodule

// File: rtl/trig_out_sel_chk.sv
// Property checker for trig_out_sel; keeps its own reference history.
module trig_out_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_sel,
    input logic       sw_update,
    input logic       cnt_en_sw,
    input logic       trig_gate_in,
    input logic       gated_mode,
    input logic       update_evt,
    input logic       ch1_match,
    input logic [5:0] cmp_ref,
    input logic       trig_out
);
    logic [5:0] h;

    // Independent copy of last cycle's references.
    always_ff @(posedge clk) begin
        if (!rst_n) h <= '0;
        else        h <= cmp_ref;
    end

    assert_swupd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd0) |=> (trig_out == $past(sw_update)));

    assert_cnten_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd1) |=> (trig_out == $past(cnt_en_sw & (trig_gate_in | ~gated_mode))));

    assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd3) |=> (trig_out == $past(ch1_match)));

    assert_ref2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd5) |=> (trig_out == $past(cmp_ref[1])));

    assert_both4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd10) |=> (trig_out == $past(cmp_ref[3] ^ h[3])));

    assert_r4f6_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 4'd13) |=>
        (trig_out == $past((cmp_ref[3] & ~h[3]) | (~cmp_ref[5] & h[5]))));

    assert_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel >= 4'd10 && cmp_ref == h) |=> !trig_out);
endmodule

bind trig_out_sel trig_out_sel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .sw_update    (sw_update),
    .cnt_en_sw    (cnt_en_sw),
    .trig_gate_in (trig_gate_in),
    .gated_mode   (gated_mode),
    .update_evt   (update_evt),
    .ch1_match    (ch1_match),
    .cmp_ref      (cmp_ref),
    .trig_out     (trig_out)
);

// File: tb/trig_out_sel_test.sv
`timescale 1ns/1ps
module trig_out_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_sel = '0;
    logic       sw_update = 0, cnt_en_sw = 0, trig_gate_in = 0, gated_mode = 0;
    logic       update_evt = 0, ch1_match = 0;
    logic [5:0] cmp_ref = '0;
    logic       trig_out;

    int   n_run = 0, n_fail = 0;
    logic exp_v;
    logic [5:0] mprev = '0;
    bit   done = 0;

    always #5 clk = ~clk;

    trig_out_sel uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_update(sw_update),
        .cnt_en_sw(cnt_en_sw), .trig_gate_in(trig_gate_in), .gated_mode(gated_mode),
        .update_evt(update_evt), .ch1_match(ch1_match), .cmp_ref(cmp_ref),
        .trig_out(trig_out)
    );

    // Expected output from the requirements, given sampled inputs and history.
    function automatic logic model(logic [3:0] m, logic [5:0] r, logic [5:0] p);
        logic [5:0] ri, fa;
        ri = r & ~p;
        fa = ~r & p;
        case (m)
            4'd0:  return sw_update;
            4'd1:  return cnt_en_sw & (trig_gate_in | ~gated_mode);
            4'd2:  return update_evt;
            4'd3:  return ch1_match;
            4'd10: return ri[3] | fa[3];
            4'd11: return ri[5] | fa[5];
            4'd12: return ri[3] | ri[5];
            4'd13: return ri[3] | fa[5];
            4'd14: return ri[4] | ri[5];
            4'd15: return ri[4] | fa[5];
            default: return r[int'(m) - 4];
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] m);
        if (m == 4'd0 || m == 4'd2) return "R2";
        if (m == 4'd1)  return "R3";
        if (m == 4'd3)  return "R4";
        if (m <= 4'd9)  return "R5";
        if (m <= 4'd11) return "R6";
        if (m == 4'd12 || m == 4'd14) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic act, logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: trig_out=%b expected=%b mode=%0d t=%0t", tag, act, expv, mode_sel, $time);
        end
    endtask

    // One clock: model at the edge, compare at the following falling edge.
    task automatic step(string tag, bit do_chk);
        @(posedge clk);
        if (!rst_n) begin exp_v = 1'b0; mprev = '0; end
        else begin exp_v = model(mode_sel, cmp_ref, mprev); mprev = cmp_ref; end
        @(negedge clk);
        if (do_chk) check(tag, trig_out, exp_v);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: expired, actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset clears output even with busy inputs.
        mode_sel = 4'd0; sw_update = 1; cmp_ref = 6'h3f;
        step("R1", 1'b1);
        step("R1", 1'b1);
        check("R1", trig_out, 1'b0);
        rst_n = 1; mode_sel = 4'd12; cmp_ref = 6'h28; sw_update = 0;
        // R1: history was low, so ch4 and ch6 high count as rising edges.
        step("R1", 1'b1);
        check("R1", trig_out, 1'b1);
        step("R1", 1'b1);
        check("R1", trig_out, 1'b0);

        // R10: output unchanged before the edge, updated right after it.
        mode_sel = 4'd5; cmp_ref = 6'h00;
        step("R10", 1'b1);
        cmp_ref = 6'h02;
        #1 check("R10", trig_out, 1'b0);
        step("R10", 1'b1);
        check("R10", trig_out, 1'b1);

        // R4: back-to-back match strobes give back-to-back highs.
        mode_sel = 4'd3; ch1_match = 1;
        step("R4", 1'b1); check("R4", trig_out, 1'b1);
        step("R4", 1'b1); check("R4", trig_out, 1'b1);
        ch1_match = 0;
        step("R4", 1'b1); check("R4", trig_out, 1'b0);

        // R3: gating blocks the enable when the gate input is low.
        mode_sel = 4'd1; cnt_en_sw = 1; gated_mode = 1; trig_gate_in = 0;
        step("R3", 1'b1); check("R3", trig_out, 1'b0);
        gated_mode = 0;
        step("R3", 1'b1); check("R3", trig_out, 1'b1);

        // R9: ch4 rises and ch6 falls together in mode 13.
        mode_sel = 4'd13; cmp_ref = 6'h20;
        step("R9", 1'b1);
        cmp_ref = 6'h08;
        step("R9", 1'b1); check("R9", trig_out, 1'b1);
        step("R9", 1'b1); check("R9", trig_out, 1'b0);

        // R11: toggle ch4 in a level mode, then enter mode 10 with it steady.
        mode_sel = 4'd0; cmp_ref = 6'h00;
        step("R11", 1'b1);
        cmp_ref = 6'h08;
        step("R11", 1'b1);
        mode_sel = 4'd10;
        step("R11", 1'b1); check("R11", trig_out, 1'b0);
        cmp_ref = 6'h00;
        step("R6", 1'b1); check("R6", trig_out, 1'b1);

        // Random cycles across all modes.
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 8) == 0) mode_sel = 4'($urandom);
            sw_update    = 1'($urandom);
            cnt_en_sw    = 1'($urandom);
            trig_gate_in = 1'($urandom);
            gated_mode   = 1'($urandom);
            update_evt   = 1'($urandom);
            ch1_match    = 1'($urandom);
            if (($urandom % 3) != 0) cmp_ref = cmp_ref ^ 6'($urandom & $urandom);
            step(tag_of(mode_sel), 1'b1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule